// File: doc/BRIEF.md
# Masked Status Interrupt Controller

This block holds event status for a host and raises one active-high interrupt line. Internal logic sends single-cycle event pulses that set sticky bits in a set of status banks (two banks of eight bits by default). Each status bank has an interrupt-enable bank of the same width, matched bit for bit. The interrupt is raised when any status bit is set and its enable bit is also set. One data-ready bit never takes part in this, whatever its enable bit holds.

The host sees a small register space with one access per clock. The host can acknowledge an interrupt in two ways. Reading a status bank returns its contents and clears that bank. Writing any value to address 0 is a start command, and it clears every status bank. The enable banks are plain read/write registers. The block has no data stream, so all of its pins are plain control and status signals. A read or write is a one-cycle strobe, with the address and write data valid in that same cycle.

Top module: `sic_top`

## Requirements
- R1: After reset all status bits and enable bits are 0 and `irq_o` is low.
- R2: An event bit at 1 in any cycle sets the matching status bit, and the bit stays set until a clear. Status bank b takes events from `evt_i[8b+7:8b]`.
- R3: Enable bank 0 sits at address 3 and enable bank 1 at address 4. A write stores the write data and a read returns it.
- R4: `irq_o` is registered. In each cycle it equals the OR, taken in the previous cycle, over all status bits ANDed with their enable bits. The data-ready bit is left out of this OR.
- R5: The data-ready bit is bit 0 of status bank 0. With only that bit set, `irq_o` stays low even when its enable bit is 1.
- R6: Status bank 0 is read at address 1 and status bank 1 at address 2. A read returns the contents held before the clear, and it clears only the bank that was read.
- R7: A write of any data to address 0 clears every status bank and leaves the enable banks unchanged.
- R8: An event that arrives in the same cycle as a clearing read or a start command wins, so its bit is set after that edge.
- R9: Writes to the status addresses change nothing. A read of address 0 returns 0 and clears nothing. Addresses 5 to 7 read as 0.
- R10: Status bits whose enable bit is 0 never raise `irq_o`. Once the status is cleared, `irq_o` falls one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 16 | Event pulses, one byte per status bank |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | One-cycle write strobe |
| host_rd | input | 1 | One-cycle read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach from the ports is an event pulse that arrives in the same cycle as a clearing access. Without priority logic, that event would be lost without any sign. The bench drives the event byte and the read or start strobe on the same falling edge. It then checks that the old value came back and that only the new event bit is still set. Showing that the data-ready bit is left out needs a second event to prove that the interrupt path works. So the bench first sets only that bit with its enable bit on, then adds a second bit.

// File: rtl/sic_pkg.sv
package sic_pkg;
  localparam int START_ADDR = 0;
  localparam int STAT_BASE  = 1;

  function automatic int en_base(input int nbank);
    return STAT_BASE + nbank;
  endfunction
endpackage

// File: rtl/sic_status_bank.sv
module sic_status_bank #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ev_i,
  input  logic              clr_i,
  input  logic              en_we_i,
  input  logic [DATA_W-1:0] en_wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic [DATA_W-1:0] en_o
);
  logic [DATA_W-1:0] stat_q, stat_d;
  logic [DATA_W-1:0] en_q;

  // events win over a clear in the same cycle
  always_comb begin
    stat_d = clr_i ? '0 : stat_q;
    stat_d = stat_d | ev_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign en_o   = en_q;
endmodule

// File: rtl/sic_host_decode.sv
module sic_host_decode #(
  parameter int NBANK  = 2,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [NBANK*DATA_W-1:0] stat_all,
  input  logic [NBANK*DATA_W-1:0] en_all,
  output logic [NBANK-1:0]        stat_clr,
  output logic [NBANK-1:0]        en_we,
  output logic                    start,
  output logic [DATA_W-1:0]       rdata
);
  localparam int EN_BASE = sic_pkg::en_base(NBANK);

  assign start = host_wr && (host_addr == ADDR_W'(sic_pkg::START_ADDR));

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_stat, hit_en;
    assign hit_stat    = host_addr == ADDR_W'(sic_pkg::STAT_BASE + b);
    assign hit_en      = host_addr == ADDR_W'(EN_BASE + b);
    assign stat_clr[b] = start || (host_rd && hit_stat);
    assign en_we[b]    = host_wr && hit_en;
  end

  always_comb begin
    rdata = '0;
    if (host_rd) begin
      for (int b = 0; b < NBANK; b++) begin
        if (host_addr == ADDR_W'(sic_pkg::STAT_BASE + b))
          rdata = stat_all[b*DATA_W +: DATA_W];
        if (host_addr == ADDR_W'(EN_BASE + b))
          rdata = en_all[b*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/sic_irq_gen.sv
module sic_irq_gen #(
  parameter int                  TOT_W     = 16,
  parameter logic [TOT_W-1:0]    EXCL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOT_W-1:0] stat_all,
  input  logic [TOT_W-1:0] en_all,
  output logic             irq_o
);
  logic pend;
  assign pend = |(stat_all & en_all & ~EXCL_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend;
  end
endmodule

// File: rtl/sic_top.sv
module sic_top #(
  parameter int NBANK     = 2,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int DRDY_BANK = 0,
  parameter int DRDY_BIT  = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK*DATA_W-1:0] evt_i,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic [DATA_W-1:0]       host_rdata,
  output logic                    irq_o
);
  localparam int TOT_W = NBANK * DATA_W;
  localparam logic [TOT_W-1:0] DRDY_MASK =
    TOT_W'(1) << (DRDY_BANK * DATA_W + DRDY_BIT);

  logic [TOT_W-1:0] stat_all, en_all;
  logic [NBANK-1:0] stat_clr, en_we;
  logic             start;

  sic_host_decode #(.NBANK(NBANK), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
    .host_wr (host_wr),
    .host_rd (host_rd),
    .host_addr(host_addr),
    .stat_all(stat_all),
    .en_all  (en_all),
    .stat_clr(stat_clr),
    .en_we   (en_we),
    .start   (start),
    .rdata   (host_rdata)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    sic_status_bank #(.DATA_W(DATA_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_i      (evt_i[b*DATA_W +: DATA_W]),
      .clr_i     (stat_clr[b]),
      .en_we_i   (en_we[b]),
      .en_wdata_i(host_wdata),
      .stat_o    (stat_all[b*DATA_W +: DATA_W]),
      .en_o      (en_all[b*DATA_W +: DATA_W])
    );
  end

  sic_irq_gen #(.TOT_W(TOT_W), .EXCL_MASK(DRDY_MASK)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_all(stat_all),
    .en_all  (en_all),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
  parameter int NBANK     = 2,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 3,
  parameter int DRDY_BANK = 0,
  parameter int DRDY_BIT  = 0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NBANK*DATA_W-1:0] evt_i,
  input logic [ADDR_W-1:0]       host_addr,
  input logic                    host_wr,
  input logic                    host_rd,
  input logic [DATA_W-1:0]       host_wdata,
  input logic [DATA_W-1:0]       host_rdata,
  input logic                    irq_o,
  input logic [NBANK*DATA_W-1:0] stat_all,
  input logic [NBANK*DATA_W-1:0] en_all
);
  localparam int TOT_W = NBANK * DATA_W;
  localparam logic [TOT_W-1:0] XMASK = TOT_W'(1) << (DRDY_BANK * DATA_W + DRDY_BIT);
  localparam logic [ADDR_W-1:0] A_ST0 = ADDR_W'(sic_pkg::STAT_BASE);
  localparam logic [ADDR_W-1:0] A_EN0 = ADDR_W'(sic_pkg::en_base(NBANK));
  localparam logic [ADDR_W-1:0] A_GO  = ADDR_W'(sic_pkg::START_ADDR);

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(stat_all & en_all & ~XMASK))); // R4

  AST_DRDY_ONLY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past((stat_all & en_all) == XMASK)) |-> !irq_o); // R5

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(host_rd) && !$past(host_wr)) |-> ((($past(stat_all) & ~stat_all)) == '0)); // R2

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(evt_i) & ~stat_all) == '0)); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_addr == A_GO) |-> (stat_all == $past(evt_i) && en_all == $past(en_all))); // R7

  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_ST0) |-> host_rdata == stat_all[DATA_W-1:0]); // R6

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_wr && host_addr == A_EN0) |-> en_all[DATA_W-1:0] == $past(host_wdata)); // R3
endmodule

bind sic_top sic_checker #(
  .NBANK(NBANK), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .DRDY_BANK(DRDY_BANK), .DRDY_BIT(DRDY_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .host_addr(host_addr),
  .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
  .host_rdata(host_rdata), .irq_o(irq_o), .stat_all(stat_all), .en_all(en_all)
);

// File: tb/tb_sic_top.sv
module tb_sic_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] evt_i = '0;
  logic [2:0]  host_addr = '0;
  logic        host_wr = 0, host_rd = 0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        irq_o;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sic_top dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] b0, input logic [7:0] b1);
    @(negedge clk); evt_i = {b1, b0};
    @(negedge clk); evt_i = '0;
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); host_addr = 3'(a); host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); host_addr = 3'(a); host_rd = 1;
    #1 d = host_rdata;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", int'(irq_o), 0);
    rd(3, v); chk("R1 en0", v, 0);
    rd(4, v); chk("R1 en1", v, 0);
    rd(1, v); chk("R1 stat0", v, 0);
    rd(2, v); chk("R1 stat1", v, 0);
  endtask

  task automatic t_enable_rw();
    logic [7:0] v;
    wr(3, 8'hA5); wr(4, 8'h3C);
    rd(3, v); chk("R3 en0", v, 8'hA5);
    rd(4, v); chk("R3 en1", v, 8'h3C);
    wr(3, 8'h00); wr(4, 8'h00);
  endtask

  task automatic t_sticky();
    logic [7:0] v;
    pulse(8'h12, 8'h00);
    pulse(8'h40, 8'h00);
    repeat (3) @(negedge clk);
    chk("R10 irq masked", int'(irq_o), 0);
    rd(1, v); chk("R2 sticky accumulate", v, 8'h52);
    rd(1, v); chk("R6 cleared after read", v, 8'h00);
  endtask

  task automatic t_irq_read_ack();
    logic [7:0] v;
    wr(4, 8'h80);
    pulse(8'h20, 8'h00);
    pulse(8'h00, 8'h80);
    chk("R4 irq lags status", int'(irq_o), 0);
    @(negedge clk); chk("R4 irq high", int'(irq_o), 1);
    rd(2, v); chk("R6 read value", v, 8'h80);
    chk("R4 irq still high at clear edge", int'(irq_o), 1);
    @(negedge clk); chk("R10 irq falls after read", int'(irq_o), 0);
    rd(1, v); chk("R6 other bank untouched", v, 8'h20);
    wr(4, 8'h00);
  endtask

  task automatic t_drdy();
    logic [7:0] v;
    wr(0, 8'h00);
    wr(3, 8'hFF);
    pulse(8'h01, 8'h00);
    repeat (2) @(negedge clk);
    chk("R5 drdy alone no irq", int'(irq_o), 0);
    pulse(8'h02, 8'h00);
    @(negedge clk); chk("R5 other bit raises irq", int'(irq_o), 1);
    wr(0, 8'h5A);
    @(negedge clk); chk("R7 irq falls after start", int'(irq_o), 0);
    rd(1, v); chk("R7 stat0 cleared", v, 0);
    rd(3, v); chk("R7 enable kept", v, 8'hFF);
    wr(3, 8'h00);
  endtask

  task automatic t_start_both();
    logic [7:0] v;
    pulse(8'h81, 8'h7E);
    wr(0, 8'hC3);
    rd(1, v); chk("R7 bank0 clear", v, 0);
    rd(2, v); chk("R7 bank1 clear", v, 0);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    wr(1, 8'hFF); wr(2, 8'hFF);
    rd(1, v); chk("R9 write stat0 ignored", v, 0);
    rd(2, v); chk("R9 write stat1 ignored", v, 0);
    pulse(8'h08, 8'h00);
    rd(0, v); chk("R9 addr0 reads zero", v, 0);
    for (int a = 5; a < 8; a++) begin
      rd(a, v); chk("R9 unmapped reads zero", v, 0);
    end
    rd(1, v); chk("R9 addr0 read no clear", v, 8'h08);
  endtask

  task automatic t_collision();
    logic [7:0] v;
    pulse(8'h30, 8'h00);
    @(negedge clk); host_addr = 3'd1; host_rd = 1; evt_i = 16'h0004;
    #1 v = host_rdata; chk("R6 pre-clear value on collision", v, 8'h30);
    @(negedge clk); host_rd = 0; evt_i = '0;
    rd(1, v); chk("R8 event beats read clear", v, 8'h04);
    pulse(8'h00, 8'h11);
    @(negedge clk); host_addr = 3'd0; host_wr = 1; evt_i = 16'h0200;
    @(negedge clk); host_wr = 0; evt_i = '0;
    rd(2, v); chk("R8 event beats start", v, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_enable_rw();
    t_sticky();
    t_irq_read_ack();
    t_drdy();
    t_start_both();
    t_ignored();
    t_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule